// File: doc/BRIEF.md
# Target Write Burst Disconnect Controller

This block sits on the bus-clock side of a target write path that feeds a write-data FIFO. On every cycle in which the initiator presents a data phase, it chooses one of three answers: accept the word by raising target-ready, stall with a wait state, or end the burst by raising stop. When the FIFO reports full, the application can ask for patience by holding an active-low burst-pending input. In that case the controller stalls for a bounded number of clocks before it disconnects. If the application does not hold that input, the disconnect is immediate. If space appears during the stall, the burst carries on.

A second function decodes the active-low last-cycle marker on the application side. During the address stage, address portions are collected and the marker closes the address. If the marker arrives before any portion has been sent, the previously latched address is announced again. During the data stage, a word may take several beats, and the marker is honoured only on the final beat of a word. A small monitor flags any burst-pending assertion shorter than two clocks.

Top module: `tw_burst_ctrl`

## Requirements
- R1: While reset is active, and in the cycle after it is released, every output is 0: `trdy`, `stop`, `hold_err`, `addr_rdy`, `word_done`, `op_end` and `addr_o`.
- R2: A cycle with `phase_req` low makes both `trdy` and `stop` low one clock later, and it clears the wait count.
- R3: A data phase (`phase_req` high, `stop` low) with `wfifo_full` low raises `trdy` one clock later.
- R4: A data phase with `wfifo_full` high and `burst_hold_n` high raises `stop` one clock later, with no wait state.
- R5: A data phase with `wfifo_full` high and `burst_hold_n` low produces L wait-state clocks, in which both `trdy` and `stop` are low, and then raises `stop`. L is the smaller of `wait_limit` and the parameter MAX_WAIT, so L = 0 gives an immediate stop.
- R6: If `wfifo_full` falls during the wait states, `trdy` rises one clock later and the wait count restarts, so a later full condition again gets the whole L clocks.
- R7: Once `stop` is high, it stays high, and `trdy` stays low, for as long as `phase_req` stays high, whatever the FIFO state is.
- R8: When `burst_hold_n` returns high after being sampled low on exactly one clock, `hold_err` pulses high for one clock, one clock after the first high sample. A low period of two or more clocks gives no pulse.
- R9: Each address portion sampled with `addr_cyc` and `addr_part_vld` high fills the next 32-bit slice of the address, starting at bits [31:0]. A portion sampled with `last_n` low closes the address: one clock later `addr_o` holds the assembled value, with any slice that was not sent equal to zero, and `addr_rdy` pulses.
- R10: `last_n` low with `addr_cyc` high, `addr_part_vld` low and no portion collected yet pulses `addr_rdy` one clock later and leaves `addr_o` unchanged.
- R11: Each data beat (`data_vld` high, `addr_cyc` low) advances a beat count. Every BEATS-th beat pulses `word_done` one clock later, together with `op_end` if `last_n` was low on that beat. `last_n` on any other beat is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_req | input | 1 | Initiator presents a data phase this cycle |
| wfifo_full | input | 1 | Write FIFO full flag, bus-clock side |
| burst_hold_n | input | 1 | Active-low request to stall rather than disconnect when full |
| wait_limit | input | LIM_W | Requested wait-state budget, clamped to MAX_WAIT |
| trdy | output | 1 | Data accepted in this phase |
| stop | output | 1 | Disconnect request |
| hold_err | output | 1 | Pulse: burst-pending held for less than two clocks |
| addr_cyc | input | 1 | Application is in the address stage |
| addr_part_vld | input | 1 | An address portion accompanies this cycle |
| addr_part | input | 32 | Address portion |
| data_vld | input | 1 | A data beat accompanies this cycle |
| last_n | input | 1 | Active-low last-cycle marker |
| addr_o | output | PARTS*32 | Latched target address |
| addr_rdy | output | 1 | Pulse: address closed or reused |
| word_done | output | 1 | Pulse: final beat of a word received |
| op_end | output | 1 | Pulse: final word of the operation |

## Verification
The bench builds the controller with MAX_WAIT = 5, LIM_W = 4, PARTS = 2 and BEATS = 3. A 4-bit `wait_limit` can request up to 15, so the clamp to MAX_WAIT is reached, along with the zero budget and several budgets in between. Three beats per word leave two interior beats on which a misplaced last-cycle marker must be ignored. Two address portions allow a full 64-bit address, a short one-portion address whose upper slice must read zero, and address reuse.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int PART_W = 32;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCEPT = 2'd1,
        PH_WAIT   = 2'd2,
        PH_STOP   = 2'd3
    } phase_e;

endpackage

// File: rtl/tw_phase_ctrl.sv
module tw_phase_ctrl
    import tw_pkg::*;
#(
    parameter int MAX_WAIT = 8,
    parameter int LIM_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_req,
    input  logic             wfifo_full,
    input  logic             burst_hold_n,
    input  logic [LIM_W-1:0] wait_limit,
    output logic             trdy,
    output logic             stop
);

    localparam int CNT_W = $clog2(MAX_WAIT + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] wcnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] lim_eff;

    always_comb begin
        if (int'(wait_limit) > MAX_WAIT) lim_eff = CNT_W'(MAX_WAIT);
        else                             lim_eff = CNT_W'(wait_limit);

        st_d = st_q;
        if (!phase_req) begin
            st_d.ph   = PH_IDLE;
            st_d.wcnt = '0;
        end else if (st_q.ph == PH_STOP) begin
            st_d.ph = PH_STOP;
        end else if (!wfifo_full) begin
            st_d.ph   = PH_ACCEPT;
            st_d.wcnt = '0;
        end else if (burst_hold_n) begin
            st_d.ph   = PH_STOP;
            st_d.wcnt = '0;
        end else if (st_q.wcnt < lim_eff) begin
            st_d.ph   = PH_WAIT;
            st_d.wcnt = st_q.wcnt + 1'b1;
        end else begin
            st_d.ph   = PH_STOP;
            st_d.wcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.wcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trdy = (st_q.ph == PH_ACCEPT);
    assign stop = (st_q.ph == PH_STOP);

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_req |=> (!trdy && !stop)); // R2
    AST_SPACE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req && !wfifo_full && !stop) |=> trdy); // R3
    AST_NOPEND_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req && wfifo_full && burst_hold_n) |=> stop); // R4
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wcnt <= CNT_W'(MAX_WAIT)); // R5
    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_req && stop) |=> (stop && !trdy)); // R7

endmodule

// File: rtl/tw_hold_check.sv
module tw_hold_check (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_hold_n,
    output logic hold_err
);

    typedef struct packed {
        logic [1:0] low_cnt;
        logic       err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (!burst_hold_n) begin
            if (st_q.low_cnt != 2'd2) st_d.low_cnt = st_q.low_cnt + 1'b1;
        end else begin
            if (st_q.low_cnt == 2'd1) st_d.err = 1'b1;
            st_d.low_cnt = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_err = st_q.err;

    AST_ERR_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_err |-> ($past(burst_hold_n) && !$past(burst_hold_n, 2))); // R8
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_err |=> !hold_err); // R8

endmodule

// File: rtl/tw_mark_decode.sv
module tw_mark_decode
    import tw_pkg::*;
#(
    parameter int PARTS = 2,
    parameter int BEATS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_cyc,
    input  logic                    addr_part_vld,
    input  logic [PART_W-1:0]       addr_part,
    input  logic                    data_vld,
    input  logic                    last_n,
    output logic [PARTS*PART_W-1:0] addr_o,
    output logic                    addr_rdy,
    output logic                    word_done,
    output logic                    op_end
);

    localparam int ADDR_W = PARTS * PART_W;
    localparam int IDX_W  = (PARTS > 1) ? $clog2(PARTS) : 1;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_a;
        logic [IDX_W-1:0]  idx;
        logic              any;
        logic [ADDR_W-1:0] addr;
        logic              rdy;
        logic [BEAT_W-1:0] beat;
        logic              wdone;
        logic              oend;
    } st_t;

    st_t               st_d, st_q;
    logic [ADDR_W-1:0] nxt_buf;

    always_comb begin
        st_d       = st_q;
        st_d.rdy   = 1'b0;
        st_d.wdone = 1'b0;
        st_d.oend  = 1'b0;
        nxt_buf    = st_q.buf_a;
        nxt_buf[int'(st_q.idx)*PART_W +: PART_W] = addr_part;

        if (addr_cyc) begin
            if (addr_part_vld) begin
                if (!last_n) begin
                    st_d.addr  = nxt_buf;
                    st_d.rdy   = 1'b1;
                    st_d.buf_a = '0;
                    st_d.idx   = '0;
                    st_d.any   = 1'b0;
                end else begin
                    st_d.buf_a = nxt_buf;
                    st_d.any   = 1'b1;
                    if (st_q.idx != IDX_W'(PARTS - 1)) st_d.idx = st_q.idx + 1'b1;
                end
            end else if (!last_n && !st_q.any) begin
                st_d.rdy = 1'b1;
            end
        end else if (data_vld) begin
            if (st_q.beat == BEAT_W'(BEATS - 1)) begin
                st_d.beat  = '0;
                st_d.wdone = 1'b1;
                st_d.oend  = !last_n;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign addr_rdy  = st_q.rdy;
    assign word_done = st_q.wdone;
    assign op_end    = st_q.oend;

    AST_ADDR_ONLY_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_rdy |-> $stable(addr_o)); // R9
    AST_NO_RDY_OUTSIDE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_cyc |=> !addr_rdy); // R10
    AST_NO_WORD_WITHOUT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_cyc || !data_vld) |=> (!word_done && !op_end)); // R11
    AST_END_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        last_n |=> !op_end); // R11

endmodule

// File: rtl/tw_burst_ctrl.sv
module tw_burst_ctrl
    import tw_pkg::*;
#(
    parameter int MAX_WAIT = 8,
    parameter int LIM_W    = 5,
    parameter int PARTS    = 2,
    parameter int BEATS    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    phase_req,
    input  logic                    wfifo_full,
    input  logic                    burst_hold_n,
    input  logic [LIM_W-1:0]        wait_limit,
    output logic                    trdy,
    output logic                    stop,
    output logic                    hold_err,
    input  logic                    addr_cyc,
    input  logic                    addr_part_vld,
    input  logic [31:0]             addr_part,
    input  logic                    data_vld,
    input  logic                    last_n,
    output logic [PARTS*32-1:0]     addr_o,
    output logic                    addr_rdy,
    output logic                    word_done,
    output logic                    op_end
);

    tw_phase_ctrl #(
        .MAX_WAIT (MAX_WAIT),
        .LIM_W    (LIM_W)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_req    (phase_req),
        .wfifo_full   (wfifo_full),
        .burst_hold_n (burst_hold_n),
        .wait_limit   (wait_limit),
        .trdy         (trdy),
        .stop         (stop)
    );

    tw_hold_check u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_hold_n (burst_hold_n),
        .hold_err     (hold_err)
    );

    tw_mark_decode #(
        .PARTS (PARTS),
        .BEATS (BEATS)
    ) u_mark (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_cyc      (addr_cyc),
        .addr_part_vld (addr_part_vld),
        .addr_part     (addr_part),
        .data_vld      (data_vld),
        .last_n        (last_n),
        .addr_o        (addr_o),
        .addr_rdy      (addr_rdy),
        .word_done     (word_done),
        .op_end        (op_end)
    );

    AST_TRDY_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(trdy && stop)); // R7

endmodule

// File: tb/tw_burst_ctrl_tb.sv
module tw_burst_ctrl_tb;

    localparam int MAXW  = 5;
    localparam int LW    = 4;
    localparam int NPART = 2;
    localparam int NBEAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_req = 0, wfifo_full = 0, burst_hold_n = 1;
    logic [LW-1:0] wait_limit = '0;
    logic addr_cyc = 0, addr_part_vld = 0, data_vld = 0, last_n = 1;
    logic [31:0] addr_part = '0;
    logic trdy, stop, hold_err, addr_rdy, word_done, op_end;
    logic [NPART*32-1:0] addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model state
    int          m_mode;   // 0 idle, 1 accept, 2 wait, 3 stop
    int          m_wc;
    int          m_low;
    logic        m_err;
    logic [31:0] m_parts[$];
    logic        m_any;
    logic [63:0] m_addr;
    logic        m_rdy;
    int          m_beat;
    logic        m_wd, m_oe;

    always #10 clk = ~clk;

    tw_burst_ctrl #(.MAX_WAIT(MAXW), .LIM_W(LW), .PARTS(NPART), .BEATS(NBEAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .phase_req(phase_req), .wfifo_full(wfifo_full),
        .burst_hold_n(burst_hold_n), .wait_limit(wait_limit), .trdy(trdy), .stop(stop),
        .hold_err(hold_err), .addr_cyc(addr_cyc), .addr_part_vld(addr_part_vld),
        .addr_part(addr_part), .data_vld(data_vld), .last_n(last_n), .addr_o(addr_o),
        .addr_rdy(addr_rdy), .word_done(word_done), .op_end(op_end));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_wc = 0; m_low = 0; m_err = 0;
            m_parts.delete(); m_any = 0; m_addr = '0; m_rdy = 0;
            m_beat = 0; m_wd = 0; m_oe = 0;
        end else begin
            int lim;
            lim = (int'(wait_limit) > MAXW) ? MAXW : int'(wait_limit);
            if (!phase_req) begin m_mode = 0; m_wc = 0; end
            else if (m_mode == 3) m_mode = 3;
            else if (!wfifo_full) begin m_mode = 1; m_wc = 0; end
            else if (burst_hold_n) begin m_mode = 3; m_wc = 0; end
            else if (m_wc < lim) begin m_mode = 2; m_wc++; end
            else begin m_mode = 3; m_wc = 0; end

            m_err = burst_hold_n && (m_low == 1);
            m_low = burst_hold_n ? 0 : m_low + 1;

            m_rdy = 0; m_wd = 0; m_oe = 0;
            if (addr_cyc) begin
                if (addr_part_vld) begin
                    if (m_parts.size() < NPART) m_parts.push_back(addr_part);
                    else m_parts[NPART-1] = addr_part;
                    if (!last_n) begin
                        m_addr = '0;
                        foreach (m_parts[i]) m_addr[i*32 +: 32] = m_parts[i];
                        m_parts.delete();
                        m_rdy = 1; m_any = 0;
                    end else m_any = 1;
                end else if (!last_n && !m_any) m_rdy = 1;
            end else if (data_vld) begin
                m_beat++;
                if (m_beat == NBEAT) begin m_beat = 0; m_wd = 1; m_oe = !last_n; end
            end
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", cur_req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("trdy", 64'(trdy), 64'(m_mode == 1));
        chk("stop", 64'(stop), 64'(m_mode == 3));
        chk("hold_err", 64'(hold_err), 64'(m_err));
        chk("addr_o", 64'(addr_o), m_addr);
        chk("addr_rdy", 64'(addr_rdy), 64'(m_rdy));
        chk("word_done", 64'(word_done), 64'(m_wd));
        chk("op_end", 64'(op_end), 64'(m_oe));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        phase_req = 0; wfifo_full = 0; burst_hold_n = 1;
        addr_cyc = 0; addr_part_vld = 0; data_vld = 0; last_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        cyc(3);
        rst_n = 1;
        cyc(2);

        cur_req = "R3";
        phase_req = 1; cyc(4);
        cur_req = "R2";
        phase_req = 0; cyc(2);

        cur_req = "R4";
        phase_req = 1; wfifo_full = 1; cyc(2);
        cur_req = "R7";
        wfifo_full = 0; cyc(3);
        quiet(); cyc(2);

        cur_req = "R5";
        wait_limit = 3; burst_hold_n = 0; phase_req = 1; wfifo_full = 1; cyc(7);
        phase_req = 0; cyc(2);
        wait_limit = 0; phase_req = 1; cyc(3);
        phase_req = 0; cyc(1);
        wait_limit = 12; phase_req = 1; cyc(9);
        quiet(); cyc(2);

        cur_req = "R6";
        wait_limit = 4; burst_hold_n = 0; phase_req = 1; wfifo_full = 1; cyc(2);
        wfifo_full = 0; cyc(1);
        wfifo_full = 1; cyc(7);
        quiet(); cyc(2);

        cur_req = "R8";
        burst_hold_n = 0; cyc(1); burst_hold_n = 1; cyc(3);
        burst_hold_n = 0; cyc(2); burst_hold_n = 1; cyc(3);
        burst_hold_n = 0; cyc(5); burst_hold_n = 1; cyc(3);

        cur_req = "R9";
        addr_cyc = 1; addr_part_vld = 1; addr_part = 32'hA5A5_0010; cyc(1);
        addr_part = 32'h0000_00C3; last_n = 0; cyc(1);
        addr_part_vld = 0; last_n = 1; cyc(2);
        addr_part_vld = 1; addr_part = 32'h1234_5678; last_n = 0; cyc(1);
        addr_part_vld = 0; last_n = 1; cyc(2);

        cur_req = "R10";
        last_n = 0; cyc(1); last_n = 1; cyc(1);
        addr_part_vld = 1; addr_part = 32'hDEAD_0000; cyc(1);
        addr_part_vld = 0; last_n = 0; cyc(1);
        addr_part_vld = 1; addr_part = 32'h0BEE_F000; cyc(1);
        quiet(); cyc(2);

        cur_req = "R11";
        data_vld = 1; last_n = 0; cyc(1);
        last_n = 1; cyc(1);
        cyc(1);
        last_n = 0; cyc(1);
        last_n = 1; cyc(2);
        last_n = 0; cyc(1);
        quiet(); cyc(2);

        cur_req = "mixed";
        for (int k = 0; k < 600; k++) begin
            phase_req     = ($urandom % 8) != 0;
            wfifo_full    = ($urandom % 3) == 0;
            burst_hold_n  = ($urandom % 4) != 0;
            wait_limit    = LW'($urandom % 16);
            addr_cyc      = ($urandom % 3) == 0;
            addr_part_vld = ($urandom % 2) == 0;
            addr_part     = $urandom;
            data_vld      = ($urandom % 2) == 0;
            last_n        = ($urandom % 4) != 0;
            cyc(1);
        end
        quiet(); cyc(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule